// File: doc/BRIEF.md
# Luma Chroma Timing Aligner

This block sits between the separation stage of a video decoder and its output formatter. It takes one luma sample stream and one chroma sample stream and delays each by its own programmable amount, so that both streams leave the block lined up with each other. Luma moves in single-clock steps. Chroma moves in whole chroma-pixel steps, and one chroma pixel spans two luma clocks.

A setting that moves a path earlier cannot look into the future. Both paths therefore run through a common base latency that covers the largest advance either path can ask for. An advance takes taps off that base, and a delay adds taps to it. Each path is a shift register with a selectable tap, followed by an output register. The adjust values can come from two 2-bit and 3-bit manual codes. In automatic mode they come instead from a small table indexed by the kind of source feeding the decoder (composite, separate luma/chroma, or component).

The controls are captured every clock into a settings register. A new setting moves the tap at once. No flushing takes place, so samples that are already in a line may repeat or be skipped across the change.

Top module: `lcta_aligner`

## Requirements
- R1: While `rst_n` is low, both outputs are 0 and the settings register holds auto mode on, source kind 00, luma code 00 and chroma code 011. After release, any output that would come from a sample older than the first clock after release is 0.
- R2: The control inputs held before clock edge m are captured at edge m. They decide which sample is put on the outputs at edge m+1, and never at edge m.
- R3: A luma sample held before edge n appears on `luma_out` right after edge n+D, where D is 4 for luma code 00, 5 for 01 (one clock later), 2 for 10 (two clocks earlier) and 3 for 11 (one clock earlier).
- R4: A chroma sample held before edge n appears on `chroma_out` right after edge n+D. D is 0 for chroma code 001 (two chroma pixels early), 2 for 010, 4 for 011 (no shift), 6 for 100, 8 for 101 and 10 for 110 (three chroma pixels late).
- R5: Chroma codes 000 and 111 are treated as 011, which gives D = 4.
- R6: With `auto_en` at 1, the manual codes have no effect on the outputs. Source kind 00 uses luma 00 with chroma 011. Kind 01 (separate luma/chroma) uses luma 01 with chroma 101. Kind 10 (component) uses luma 01 with chroma 110. Kind 11 behaves as 00.
- R7: When the setting changes, the output at each following edge is the sample selected by the new tap count from the unflushed history, even if that repeats or skips samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one luma sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| luma_in | input | LUMA_W | Luma sample stream |
| chroma_in | input | CHROMA_W | Chroma sample stream |
| luma_adj | input | 2 | Manual luma shift code |
| chroma_adj | input | 3 | Manual chroma shift code |
| auto_en | input | 1 | 1 selects the shift codes from `src_kind` |
| src_kind | input | 2 | Source kind: 00 composite, 01 separate luma/chroma, 10 component, 11 as composite |
| luma_out | output | LUMA_W | Aligned luma |
| chroma_out | output | CHROMA_W | Aligned chroma |

## Verification
The output after edge n is due from the sample held before edge n-D, where D comes from the setting captured at edge n-1. So a control change takes one edge to reach the settings register and shows in the data at the next edge. The bench keeps a per-cycle history of samples and controls. It samples both outputs at the falling edge after each rising edge and looks up the expected value by the tap count in force at that edge, with zero for history older than the release of reset. Each check is tagged R2 when the setting just changed, R7 within the following eleven cycles, and otherwise by mode and path.

// File: rtl/lcta_pkg.sv
package lcta_pkg;

   typedef enum logic [1:0] {
      SRC_COMPOSITE = 2'b00,
      SRC_YC        = 2'b01,
      SRC_COMPONENT = 2'b10,
      SRC_SPARE     = 2'b11
   } src_kind_e;

   typedef struct packed {
      logic       auto_en;
      src_kind_e  src;
      logic [1:0] l_code;
      logic [2:0] c_code;
   } lcta_ctrl_t;

   localparam lcta_ctrl_t CTRL_RST = '{auto_en: 1'b1, src: SRC_COMPOSITE,
                                       l_code: 2'b00, c_code: 3'b011};

   // Largest moves each path may request (luma clocks / chroma pixels)
   localparam int LUMA_MAX_ADV   = 2;
   localparam int LUMA_MAX_DLY   = 1;
   localparam int CHROMA_MAX_ADV = 2;
   localparam int CHROMA_MAX_DLY = 3;

   // Signed luma move in clocks: positive = later
   function automatic int luma_shift(input logic [1:0] code);
      case (code)
         2'b01:   return 1;
         2'b10:   return -2;
         2'b11:   return -1;
         default: return 0;
      endcase
   endfunction

   // Signed chroma move in chroma pixels: positive = later; spare codes = none
   function automatic int chroma_steps(input logic [2:0] code);
      case (code)
         3'b001:  return -2;
         3'b010:  return -1;
         3'b100:  return 1;
         3'b101:  return 2;
         3'b110:  return 3;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/lcta_tap_delay.sv
module lcta_tap_delay #(
   parameter int W     = 10,
   parameter int DEPTH = 5,
   parameter int TAP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     din,
   input  logic [TAP_W-1:0] tap,
   output logic [W-1:0]     dout
);

   logic [W-1:0] sel;

   generate
      if (DEPTH == 0) begin : g_direct
         assign sel = din;
      end else begin : g_line
         logic [W-1:0] line [DEPTH];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) line[i] <= '0;
            end else begin
               line[0] <= din;
               for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
            end
         end

         always_comb begin
            sel = din;
            for (int i = 0; i < DEPTH; i++)
               if (tap == TAP_W'(i + 1)) sel = line[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else        dout <= sel;
   end

   // R3 / R4: a requested tap never reaches past the end of the line
   assert_tap_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(tap) <= DEPTH);

endmodule

// File: rtl/lcta_ctrl_reg.sv
module lcta_ctrl_reg
   import lcta_pkg::*;
#(
   parameter int BASE   = 4,
   parameter int CSTEP  = 2,
   parameter int LTAP_W = 3,
   parameter int CTAP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lcta_ctrl_t        ctrl_in,
   output logic [LTAP_W-1:0] luma_tap,
   output logic [CTAP_W-1:0] chroma_tap
);

   lcta_ctrl_t ctrl_q;
   logic [1:0] l_eff;
   logic [2:0] c_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= CTRL_RST;
      else        ctrl_q <= ctrl_in;
   end

   // Resolve automatic choices by source kind
   always_comb begin
      l_eff = ctrl_q.l_code;
      c_eff = ctrl_q.c_code;
      if (ctrl_q.auto_en) begin
         case (ctrl_q.src)
            SRC_YC:        begin l_eff = 2'b01; c_eff = 3'b101; end
            SRC_COMPONENT: begin l_eff = 2'b01; c_eff = 3'b110; end
            default:       begin l_eff = 2'b00; c_eff = 3'b011; end
         endcase
      end
   end

   assign luma_tap   = LTAP_W'(BASE + luma_shift(l_eff));
   assign chroma_tap = CTAP_W'(BASE + CSTEP * chroma_steps(c_eff));

endmodule

// File: rtl/lcta_aligner.sv
module lcta_aligner
   import lcta_pkg::*;
#(
   parameter int LUMA_W   = 10,
   parameter int CHROMA_W = 10,
   parameter int CSTEP    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LUMA_W-1:0]   luma_in,
   input  logic [CHROMA_W-1:0] chroma_in,
   input  logic [1:0]          luma_adj,
   input  logic [2:0]          chroma_adj,
   input  logic                auto_en,
   input  logic [1:0]          src_kind,
   output logic [LUMA_W-1:0]   luma_out,
   output logic [CHROMA_W-1:0] chroma_out
);

   localparam int C_ADV   = CHROMA_MAX_ADV * CSTEP;
   localparam int BASE    = (LUMA_MAX_ADV > C_ADV) ? LUMA_MAX_ADV : C_ADV;
   localparam int L_DEPTH = BASE + LUMA_MAX_DLY;
   localparam int C_DEPTH = BASE + CHROMA_MAX_DLY * CSTEP;
   localparam int LTAP_W  = $clog2(L_DEPTH + 1);
   localparam int CTAP_W  = $clog2(C_DEPTH + 1);

   generate
      if (LUMA_W < 1 || CHROMA_W < 1) begin : g_bad_w
         $error("lcta_aligner: sample widths must be at least 1");
      end
      if (CSTEP < 1) begin : g_bad_step
         $error("lcta_aligner: CSTEP must be at least 1");
      end
   endgenerate

   lcta_ctrl_t        ctrl_in;
   logic [LTAP_W-1:0] luma_tap;
   logic [CTAP_W-1:0] chroma_tap;

   assign ctrl_in = '{auto_en: auto_en, src: src_kind_e'(src_kind),
                      l_code: luma_adj, c_code: chroma_adj};

   lcta_ctrl_reg #(.BASE(BASE), .CSTEP(CSTEP), .LTAP_W(LTAP_W), .CTAP_W(CTAP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_in(ctrl_in),
      .luma_tap(luma_tap), .chroma_tap(chroma_tap)
   );

   lcta_tap_delay #(.W(LUMA_W), .DEPTH(L_DEPTH), .TAP_W(LTAP_W)) u_luma (
      .clk(clk), .rst_n(rst_n), .din(luma_in), .tap(luma_tap), .dout(luma_out)
   );

   lcta_tap_delay #(.W(CHROMA_W), .DEPTH(C_DEPTH), .TAP_W(CTAP_W)) u_chroma (
      .clk(clk), .rst_n(rst_n), .din(chroma_in), .tap(chroma_tap), .dout(chroma_out)
   );

   // R6: automatic table, whatever the manual codes hold
   assert_auto_composite_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && (src_kind == 2'b00 || src_kind == 2'b11))
      |=> (luma_tap == LTAP_W'(BASE) && chroma_tap == CTAP_W'(BASE)));

   assert_auto_yc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && src_kind == 2'b01)
      |=> (luma_tap == LTAP_W'(BASE + 1) && chroma_tap == CTAP_W'(BASE + 2 * CSTEP)));

   assert_auto_component_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && src_kind == 2'b10)
      |=> (luma_tap == LTAP_W'(BASE + 1) && chroma_tap == CTAP_W'(BASE + 3 * CSTEP)));

   // R5: spare chroma codes act as no shift
   assert_spare_chroma_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_en && (chroma_adj == 3'b000 || chroma_adj == 3'b111))
      |=> (chroma_tap == CTAP_W'(BASE)));

   // R3: nominal manual luma code leaves luma on the base latency
   assert_manual_luma_nominal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_en && luma_adj == 2'b00) |=> (luma_tap == LTAP_W'(BASE)));

endmodule

// File: tb/tb_lcta_aligner.sv
`timescale 1ns/1ps
module tb_lcta_aligner;

   localparam int HN = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] luma_in = '0, chroma_in = '0;
   logic [1:0] luma_adj = 2'b00;
   logic [2:0] chroma_adj = 3'b011;
   logic       auto_en = 1'b1;
   logic [1:0] src_kind = 2'b00;
   logic [9:0] luma_out, chroma_out;

   lcta_aligner dut (
      .clk(clk), .rst_n(rst_n), .luma_in(luma_in), .chroma_in(chroma_in),
      .luma_adj(luma_adj), .chroma_adj(chroma_adj), .auto_en(auto_en),
      .src_kind(src_kind), .luma_out(luma_out), .chroma_out(chroma_out)
   );

   always #5 clk = ~clk;

   int tests = 0, fails = 0;
   int n = 0;
   int last_chg = -100;
   int hl [HN];
   int hc [HN];
   int el [HN];
   int ec [HN];
   int rcode [HN];
   int rauto [HN];
   bit done = 0;

   // Expected tap counts from the requirement tables
   function automatic int ktap_l(input int code);
      case (code)
         1: return 5;  2: return 2;  3: return 3;
         default: return 4;
      endcase
   endfunction

   function automatic int ktap_c(input int code);
      case (code)
         1: return 0;  2: return 2;  4: return 6;
         5: return 8;  6: return 10;
         default: return 4;
      endcase
   endfunction

   function automatic int eff_l(input int a, input int s, input int lc);
      if (a == 0) return lc;
      return (s == 1 || s == 2) ? 1 : 0;
   endfunction

   function automatic int eff_c(input int a, input int s, input int cc);
      if (a == 0) return cc;
      if (s == 1) return 5;
      if (s == 2) return 6;
      return 3;
   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, n, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, let the rising edge pass, check at the next falling edge
   task automatic cycle();
      int l_now, c_now, l_prev, c_prev, kl, kc, il, ic, el_exp, ec_exp;
      string tl, tc;
      if (n >= HN) return;
      hl[n] = int'(luma_in);  hc[n] = int'(chroma_in);
      rcode[n] = int'(chroma_adj);  rauto[n] = int'(auto_en);
      l_now = eff_l(int'(auto_en), int'(src_kind), int'(luma_adj));
      c_now = eff_c(int'(auto_en), int'(src_kind), int'(chroma_adj));
      el[n] = l_now;  ec[n] = c_now;
      l_prev = (n == 0) ? 0 : el[n-1];
      c_prev = (n == 0) ? 3 : ec[n-1];
      if (l_now != l_prev || c_now != c_prev) last_chg = n;
      @(posedge clk);
      @(negedge clk);
      kl = ktap_l((n == 0) ? 0 : el[n-1]);
      kc = ktap_c((n == 0) ? 3 : ec[n-1]);
      il = n - kl;  ic = n - kc;
      el_exp = (il < 0) ? 0 : hl[il];
      ec_exp = (ic < 0) ? 0 : hc[ic];
      if (n >= 1 && last_chg == n - 1) begin tl = "R2"; tc = "R2"; end
      else if (n >= 1 && n - 1 - last_chg <= 11 && last_chg >= 0) begin tl = "R7"; tc = "R7"; end
      else if (n >= 1 && rauto[n-1] != 0) begin tl = "R6"; tc = "R6"; end
      else if (n < 11) begin tl = "R1"; tc = "R1"; end
      else begin
         tl = "R3";
         tc = (rcode[n-1] == 0 || rcode[n-1] == 7) ? "R5" : "R4";
      end
      check(tl, int'(luma_out), el_exp, "luma_out");
      check(tc, int'(chroma_out), ec_exp, "chroma_out");
      n++;
   endtask

   task automatic rand_data();
      luma_in   = 10'($urandom);
      chroma_in = 10'($urandom);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd2024));
      // R1: outputs held at zero during reset while inputs toggle
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         rand_data();
         check("R1", int'(luma_out), 0, "luma_out in reset");
         check("R1", int'(chroma_out), 0, "chroma_out in reset");
      end
      @(negedge clk);
      rst_n = 1'b1;
      luma_adj = 2'b10;  chroma_adj = 3'b001;   // ignored: auto is on (R6)
      // R1/R6: default setting right after release
      for (int i = 0; i < 20; i++) begin rand_data(); cycle(); end
      // R3/R4/R5: every manual code pair held long enough to settle
      auto_en = 1'b0;
      for (int lc = 0; lc < 4; lc++) begin
         for (int cc = 0; cc < 8; cc++) begin
            luma_adj = 2'(lc);  chroma_adj = 3'(cc);
            for (int i = 0; i < 16; i++) begin rand_data(); cycle(); end
         end
      end
      // R6: each source kind, with the manual codes changing every cycle
      auto_en = 1'b1;
      for (int s = 0; s < 4; s++) begin
         src_kind = 2'(s);
         for (int i = 0; i < 20; i++) begin
            luma_adj = 2'($urandom);  chroma_adj = 3'($urandom);
            rand_data(); cycle();
         end
      end
      // R7: largest jumps, counting ramp to expose repeats and skips
      auto_en = 1'b0;  luma_adj = 2'b10;  chroma_adj = 3'b001;
      for (int i = 0; i < 14; i++) begin luma_in = 10'(i); chroma_in = 10'(i); cycle(); end
      luma_adj = 2'b01;  chroma_adj = 3'b110;
      for (int i = 0; i < 14; i++) begin luma_in = 10'(100 + i); chroma_in = 10'(100 + i); cycle(); end
      luma_adj = 2'b10;  chroma_adj = 3'b001;
      for (int i = 0; i < 14; i++) begin luma_in = 10'(200 + i); chroma_in = 10'(200 + i); cycle(); end
      // Random mix of settings and data
      for (int i = 0; i < 1500; i++) begin
         if (($urandom % 16) == 0) begin
            auto_en    = 1'($urandom);
            src_kind   = 2'($urandom);
            luma_adj   = 2'($urandom);
            chroma_adj = 3'($urandom);
         end
         rand_data(); cycle();
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule